// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Protocol Engine

This block is the bus side of a 1024-byte serial memory. It watches the two-wire clock and data lines, which arrive already synchronised to a fast system clock, and finds the start, repeated start and stop conditions. It shifts bytes in and out most significant bit first. It acknowledges by enabling an open-drain pull-down on the data line, and it drives read data through the same enable. It keeps a 10-bit word pointer for the whole array.

Writes leave the block as a stream of byte strobes, each carrying an address and a data byte. A one-cycle commit pulse follows the stop condition. A separate write engine buffers those bytes, programs the array, and reports that it is busy while the internal write cycle runs. Reads are served from a synchronous memory read port with one cycle of latency. The block fetches each byte before the clock low phase in which its first bit must appear.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, and in idle, the data-line enable `sda_oe_o` is 0. A start (data falling while clock is high) begins reception of a fresh control byte from any state, including the middle of a byte. A stop (data rising while clock is high) returns the block to idle. A partial byte cut short by either condition has no effect.
- R2: The control byte is accepted only when bits 7..4 equal 1010 and bit 3 equals `chip_sel_i`. Bit 0 selects the direction: 1 is read, 0 is write. An accepted byte is acknowledged by holding `sda_oe_o` high through the 9th clock. A rejected byte gets no acknowledge, and the block keeps the line released until the next start.
- R3: While `wr_busy_i` is high, no control byte is acknowledged. This holds for both read and write.
- R4: In a write, control-byte bits 2..1 load pointer bits 9..8. The next byte loads pointer bits 7..0. Each later byte is acknowledged and emitted as a one-cycle `wr_byte_vld_o` carrying the current pointer and the byte. After each such byte the pointer's low 4 bits advance and wrap inside the 16-byte page, while bits 9..4 stay unchanged.
- R5: `wr_commit_o` pulses once after a stop, and only if at least one data byte was accepted since the last start. A start discards that pending state.
- R6: While `wp_i` is high, the control byte and the word address are still acknowledged. Any data byte is refused: it gets no acknowledge, no byte strobe and no commit.
- R7: A read control byte sends the byte at the current pointer, most significant bit first. Each bit is driven while the clock is low (`sda_oe_o` = 1 means the bit is 0). The pointer advances by one after each byte sent. Bits 2..1 of a read control byte are ignored.
- R8: A write-direction address phase followed by a repeated start and a read control byte returns the byte stored at the address just loaded.
- R9: In a read, each master acknowledge fetches the next address. The increment covers all 10 bits, so it crosses pages and wraps from 1023 to 0. A master non-acknowledge ends the read, and the line stays released until a start or stop.
- R10: `sda_oe_o` never changes while the clock line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired level) |
| chip_sel_i | input | 1 | Strap value compared with control-byte bit 3 |
| wp_i | input | 1 | Write protect: refuse all data bytes when high |
| wr_busy_i | input | 1 | Write engine is running an internal write cycle |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |
| wr_byte_vld_o | output | 1 | One-cycle strobe for an accepted write byte |
| wr_byte_addr_o | output | ADDR_W | Array address of the strobed byte |
| wr_byte_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse after a stop that closes an accepted write |
| rd_en_o | output | 1 | Read request to the synchronous memory port |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | 8 | Read data, valid one cycle after `rd_en_o` |

## Verification
The hardest states to reach from the ports are the ones entered only partway through a byte. Examples are a repeated start after four bits of an address byte, and a stop three bits into a data byte. A bit-level bus driver in the bench can stop after any number of bits and then raise the condition, so these aborts are produced directly and then followed by a read that shows the pointer was untouched. Refusal while busy needs a write engine that really holds busy. The bench models one that raises busy for a fixed time after each commit, and it polls both during that window and after it ends.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_ADDR, S_DATA, S_ACK, S_TX, S_TX_ACK, S_HOLD
  } phase_t;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2cm_line_events.sv
module i2cm_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2cm_word_ptr.sv
module i2cm_word_ptr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_hi,
  input  logic [ADDR_W-9:0] hi_val,
  input  logic              ld_lo,
  input  logic [7:0]        lo_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else begin
      if (ld_hi)    ptr[ADDR_W-1:8] <= hi_val;
      if (ld_lo)    ptr[7:0]        <= lo_val;
      if (inc_page) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      if (inc_full) ptr             <= ptr + 1'b1;
    end
  end

  // R4: the phase controller never loads and advances in the same cycle
  p_ptr_cmd_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !((ld_lo || ld_hi) && (inc_page || inc_full)));

  // R4: a page advance keeps the page bits
  p_page_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    inc_page |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              chip_sel_i,
  input  logic              wp_i,
  input  logic              wr_busy_i,
  output logic              sda_oe_o,
  output logic              wr_byte_vld_o,
  output logic [ADDR_W-1:0] wr_byte_addr_o,
  output logic [7:0]        wr_byte_data_o,
  output logic              wr_commit_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  logic scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] ptr;
  phase_t state, nxt_phase;
  logic [CNT_W-1:0] cnt;
  logic [7:0] sreg, txsr;
  logic pend, fetch_req, rd_vld_q, m_ack;
  logic byte_end, ctrl_ok;
  logic ld_hi, ld_lo, inc_page, inc_full;

  i2cm_line_events u_ev (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  always_comb begin
    byte_end = scl_fall && (cnt == BYTE_BITS);
    ctrl_ok  = (sreg[7:4] == DEV_CODE) && (sreg[3] == chip_sel_i) && !wr_busy_i;
    ld_hi    = (state == S_CTRL) && byte_end && ctrl_ok && !sreg[0];
    ld_lo    = (state == S_ADDR) && byte_end;
    inc_page = (state == S_DATA) && byte_end && !wp_i;
    inc_full = (state == S_TX)   && byte_end;
  end

  i2cm_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst),
    .ld_hi(ld_hi), .hi_val(sreg[HI_W:1]),
    .ld_lo(ld_lo), .lo_val(sreg),
    .inc_page(inc_page), .inc_full(inc_full),
    .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= S_IDLE;
      nxt_phase      <= S_IDLE;
      cnt            <= '0;
      sreg           <= '0;
      txsr           <= '0;
      pend           <= 1'b0;
      fetch_req      <= 1'b0;
      rd_vld_q       <= 1'b0;
      m_ack          <= 1'b0;
      sda_oe_o       <= 1'b0;
      wr_byte_vld_o  <= 1'b0;
      wr_byte_addr_o <= '0;
      wr_byte_data_o <= '0;
      wr_commit_o    <= 1'b0;
      rd_en_o        <= 1'b0;
      rd_addr_o      <= '0;
    end else begin
      wr_byte_vld_o <= 1'b0;
      wr_commit_o   <= 1'b0;
      rd_en_o       <= 1'b0;
      fetch_req     <= 1'b0;
      rd_vld_q      <= rd_en_o;
      if (fetch_req) begin
        rd_en_o   <= 1'b1;
        rd_addr_o <= ptr;
      end
      if (rd_vld_q) txsr <= rd_data_i;

      if (start_det) begin
        state    <= S_CTRL;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
        pend     <= 1'b0;
      end else if (stop_det) begin
        state       <= S_IDLE;
        cnt         <= '0;
        sda_oe_o    <= 1'b0;
        wr_commit_o <= pend;
        pend        <= 1'b0;
      end else begin
        case (state)
          S_CTRL, S_ADDR, S_DATA: begin
            if (scl_rise) begin
              sreg <= {sreg[6:0], sda_i};
              cnt  <= cnt + 1'b1;
            end
            if (byte_end) begin
              cnt <= '0;
              if (state == S_CTRL) begin
                if (ctrl_ok) begin
                  sda_oe_o  <= 1'b1;
                  state     <= S_ACK;
                  nxt_phase <= sreg[0] ? S_TX : S_ADDR;
                  fetch_req <= sreg[0];
                end else begin
                  state <= S_HOLD;
                end
              end else if (state == S_ADDR) begin
                sda_oe_o  <= 1'b1;
                state     <= S_ACK;
                nxt_phase <= S_DATA;
              end else if (!wp_i) begin
                sda_oe_o       <= 1'b1;
                state          <= S_ACK;
                nxt_phase      <= S_DATA;
                pend           <= 1'b1;
                wr_byte_vld_o  <= 1'b1;
                wr_byte_addr_o <= ptr;
                wr_byte_data_o <= sreg;
              end else begin
                state <= S_HOLD;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              state <= nxt_phase;
              cnt   <= '0;
              if (nxt_phase == S_TX) begin
                sda_oe_o <= ~txsr[7];
                txsr     <= {txsr[6:0], 1'b0};
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == BYTE_BITS) begin
                sda_oe_o  <= 1'b0;
                state     <= S_TX_ACK;
                fetch_req <= 1'b1;
                m_ack     <= 1'b0;
                cnt       <= '0;
              end else begin
                sda_oe_o <= ~txsr[7];
                txsr     <= {txsr[6:0], 1'b0};
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) m_ack <= ~sda_i;
            if (scl_fall) begin
              if (m_ack) begin
                state    <= S_TX;
                sda_oe_o <= ~txsr[7];
                txsr     <= {txsr[6:0], 1'b0};
              end else begin
                state <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the line enable holds still through every clock-high phase
  p_sda_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R6: no byte strobe follows a cycle with write protect raised
  p_no_wp_write_r6: assert property (@(posedge clk) disable iff (rst)
    wr_byte_vld_o |-> !$past(wp_i));

  // R5: a commit comes only right after a stop
  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    wr_commit_o |-> $past(stop_det));

  // R4: strobe, commit and read request never overlap
  p_port_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_byte_vld_o, wr_commit_o, rd_en_o}));

  // R3: a control byte closing while busy leaves the line released
  p_busy_nack_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_CTRL && byte_end && wr_busy_i && !start_det && !stop_det) |=> !sda_oe_o);
endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int AW = 10;
  localparam int BUSY_CYC = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic chip_sel = 1'b0;
  logic wp = 1'b0;
  logic wr_busy;
  logic sda_oe, wr_byte_vld, wr_commit, rd_en;
  logic [AW-1:0] wr_byte_addr, rd_addr;
  logic [7:0] wr_byte_data, rd_data;
  logic sda_line;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_slave #(.ADDR_W(AW), .PAGE_W(4)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .chip_sel_i(chip_sel), .wp_i(wp), .wr_busy_i(wr_busy),
    .sda_oe_o(sda_oe), .wr_byte_vld_o(wr_byte_vld),
    .wr_byte_addr_o(wr_byte_addr), .wr_byte_data_o(wr_byte_data),
    .wr_commit_o(wr_commit), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  function automatic logic [7:0] ival(int a);
    return 8'((a * 29 + 11) & 8'hFF);
  endfunction

  // memory and write-engine model
  logic [7:0] mem [1024];
  logic [AW-1:0] stg_a [16];
  logic [7:0] stg_d [16];
  int stg_n = 0, busy_cnt = 0, commit_n = 0, log_n = 0;
  logic [AW-1:0] log_a [64];
  logic [7:0] log_d [64];
  assign wr_busy = (busy_cnt != 0);

  initial for (int i = 0; i < 1024; i++) mem[i] = ival(i);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_byte_vld) begin
      stg_a[stg_n % 16] = wr_byte_addr;
      stg_d[stg_n % 16] = wr_byte_data;
      stg_n = stg_n + 1;
      log_a[log_n % 64] = wr_byte_addr;
      log_d[log_n % 64] = wr_byte_data;
      log_n = log_n + 1;
    end
    if (wr_commit) begin
      for (int k = 0; k < stg_n && k < 16; k++) mem[stg_a[k]] = stg_d[k];
      stg_n = 0;
      busy_cnt = BUSY_CYC;
      commit_n = commit_n + 1;
    end else if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp=<150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic hp(); repeat (8) @(posedge clk); #1; endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp(); hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    sda_m = 1'b1; hp(); scl = 1'b1; hp();
    ack = (sda_line == 1'b0);
    scl = 1'b0; hp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    hp();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl = 1'b1; hp(); b[i] = sda_line; scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy_cnt > 0) begin @(posedge clk); #1; end
    hp();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
    chk(wr_byte_vld == 1'b0 && wr_commit == 1'b0, "R1", "no strobe after reset", {wr_byte_vld, wr_commit}, 0);
  endtask

  task automatic t_byte_write_poll();
    bit a0, a1, a2;
    bus_start(); send_byte(8'hA2, a0); send_byte(8'h34, a1); send_byte(8'hA5, a2); bus_stop();
    chk(a0 && a1 && a2, "R2", "acks on byte write", {a0, a1, a2}, 3'b111);
    chk(log_n == 1 && log_a[0] == 10'h134 && log_d[0] == 8'hA5, "R4", "byte strobe addr", log_a[0], 10'h134);
    chk(commit_n == 1, "R5", "commit after stop", commit_n, 1);
    bus_start(); send_byte(8'hA2, a0); bus_stop();
    chk(!a0, "R3", "control byte refused while busy", a0, 0);
    chk(commit_n == 1, "R5", "no commit for address-less poll", commit_n, 1);
    wait_idle();
    bus_start(); send_byte(8'hA2, a0); bus_stop();
    chk(a0, "R3", "control byte accepted after busy", a0, 1);
    chk(commit_n == 1, "R5", "no commit without data", commit_n, 1);
  endtask

  task automatic t_page_write();
    bit a;
    bit all_ack = 1;
    logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    logic [AW-1:0] ea [4] = '{10'h22E, 10'h22F, 10'h220, 10'h221};
    bus_start(); send_byte(8'hA4, a); send_byte(8'h2E, a);
    for (int i = 0; i < 4; i++) begin send_byte(d[i], a); all_ack &= a; end
    bus_stop();
    chk(all_ack, "R4", "page data acks", all_ack, 1);
    for (int i = 0; i < 4; i++)
      chk(log_a[1+i] == ea[i] && log_d[1+i] == d[i], "R4", "page wrap address", log_a[1+i], ea[i]);
    chk(commit_n == 2, "R5", "page commit", commit_n, 2);
    wait_idle();
  endtask

  task automatic t_random_read();
    bit a; logic [7:0] b;
    bus_start(); send_byte(8'hA2, a); send_byte(8'h34, a);
    bus_start(); send_byte(8'hA3, a); recv_byte(1'b0, b); bus_stop();
    chk(b == 8'hA5, "R8", "random read of written byte", b, 8'hA5);
  endtask

  task automatic t_current_read();
    bit a; logic [7:0] b;
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, b); bus_stop();
    chk(a, "R7", "read control ack", a, 1);
    chk(b == ival(10'h135), "R7", "current address read", b, ival(10'h135));
  endtask

  task automatic t_seq_read();
    bit a; logic [7:0] b;
    logic [7:0] exp [4] = '{ival(10'h3FE), ival(10'h3FF), ival(0), ival(1)};
    bus_start(); send_byte(8'hA4, a); send_byte(8'h2F, a);
    bus_start(); send_byte(8'hA5, a);
    recv_byte(1'b1, b); chk(b == 8'h22, "R9", "seq read page byte", b, 8'h22);
    recv_byte(1'b0, b); chk(b == ival(10'h230), "R9", "seq read crosses page", b, ival(10'h230));
    bus_stop();
    bus_start(); send_byte(8'hA6, a); send_byte(8'hFE, a);
    bus_start(); send_byte(8'hA7, a);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i < 3, b);
      chk(b == exp[i], "R9", "seq read wrap", b, exp[i]);
    end
    send_byte(8'hFF, a);
    chk(!a && sda_oe == 1'b0, "R9", "released after master nack", a, 0);
    bus_stop();
  endtask

  task automatic t_wp();
    bit a0, a1, a2; logic [7:0] b;
    int ln = log_n, cn = commit_n;
    wp = 1'b1;
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h10, a1); send_byte(8'h5A, a2); bus_stop();
    chk(a0 && a1, "R6", "ctrl/addr acked under protect", {a0, a1}, 2'b11);
    chk(!a2, "R6", "data refused under protect", a2, 0);
    chk(log_n == ln && commit_n == cn && busy_cnt == 0, "R6", "no strobe/commit", log_n - ln, 0);
    wp = 1'b0;
    bus_start(); send_byte(8'hA0, a0); send_byte(8'h10, a0);
    bus_start(); send_byte(8'hA1, a0); recv_byte(1'b0, b); bus_stop();
    chk(b == ival(10'h010), "R6", "protected byte unchanged", b, ival(10'h010));
  endtask

  task automatic t_select();
    bit a; logic [7:0] b;
    bus_start(); send_byte(8'hA8, a);
    chk(!a, "R2", "strap mismatch refused", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R2", "silent until next start", a, 0);
    bus_stop();
    bus_start(); send_byte(8'hB0, a); bus_stop();
    chk(!a, "R2", "wrong device code refused", a, 0);
    chip_sel = 1'b1;
    bus_start(); send_byte(8'hA9, a); recv_byte(1'b0, b); bus_stop();
    chk(a && b == ival(10'h011), "R2", "strap match read", b, ival(10'h011));
    chip_sel = 1'b0;
  endtask

  task automatic t_abort();
    bit a; logic [7:0] b;
    int ln, cn;
    bus_start(); send_byte(8'hA0, a); send_bits(8'hFF, 4);
    bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, b); bus_stop();
    chk(b == ival(10'h012), "R1", "mid-byte start leaves pointer", b, ival(10'h012));
    ln = log_n; cn = commit_n;
    bus_start(); send_byte(8'hA0, a); send_byte(8'h40, a); send_bits(8'h00, 3); bus_stop();
    chk(log_n == ln && commit_n == cn, "R1", "mid-byte stop writes nothing", log_n - ln, 0);
    chk(sda_oe == 1'b0, "R10", "released in idle", sda_oe, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    hp();
    t_reset();
    t_byte_write_poll();
    t_page_write();
    t_random_read();
    t_current_read();
    t_seq_read();
    t_wp();
    t_select();
    t_abort();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule